// File: doc/BRIEF.md
# Wake-up handshake sequencer

This block brings a device out of its low-power SLEEP state, or out of a supply reset, and into STANDBY. It talks to an external controller through two pins. The controller raises the active-low sleep request pin to ask for wake-up. The device answers on its active-low fault pin, which doubles as a handshake line. After the wake request has been registered, the fault pin is pulled low. This tells the controller that the device is ready to communicate while it initializes.

A mode input selects how the handshake ends. Without acknowledge, the fault pin is released as soon as initialization is complete, and the block settles in STANDBY. With acknowledge, the pin stays low after initialization until the controller sends a short low pulse on the sleep pin. Only then is the pin released and STANDBY entered. A low level on the sleep pin that lasts long enough returns the block to SLEEP from any state. While the supply-reset input is high, everything is held in reset. When it falls, the same sequence runs again. A state output exposes the sequence for observation.

Top module: `wake_handshake_seq`

## Requirements
- R1: While `por_i` is high, the block is held in SLEEP with `nfault_o` high, whatever `nsleep_i` does, and it enters SLEEP at once when `por_i` rises.
- R2: In SLEEP, a high level on `nsleep_i` moves the block to WAKE three clock edges after it is applied: two synchronizer stages and then the state register. WAKE lasts TWAKE cycles with `nfault_o` high.
- R3: After WAKE, the block spends exactly TINIT cycles in INIT with `nfault_o` low.
- R4: With `ack_mode_i` low, INIT is followed by STANDBY with `nfault_o` high.
- R5: With `ack_mode_i` high, INIT is followed by WAIT_ACK, and `nfault_o` stays low.
- R6: In WAIT_ACK, a low pulse on `nsleep_i` lasting from TPULSE_MIN to TSLEEP_MIN-1 cycles moves the block to STANDBY with `nfault_o` high. The pulse must have started after WAIT_ACK was entered.
- R7: In WAIT_ACK, a low pulse shorter than TPULSE_MIN cycles is ignored: the state and `nfault_o` are unchanged.
- R8: A low pulse of acknowledge width during INIT is not taken as an acknowledge. INIT still lasts TINIT cycles, and the block then waits in WAIT_ACK.
- R9: From any state other than SLEEP, a low on `nsleep_i` lasting TSLEEP_MIN cycles returns the block to SLEEP with `nfault_o` high.
- R10: When `por_i` falls while `nsleep_i` is high, the block runs the wake sequence through WAKE and INIT, and releases according to `ack_mode_i`.
- R11: `state_o` encodes SLEEP=0, WAKE=1, INIT=2, WAIT_ACK=3 and STANDBY=4, and the state moves only along the transitions given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Supply reset, active high, asynchronous assert |
| nsleep_i | input | 1 | Sleep request, active low, asynchronous to clk |
| ack_mode_i | input | 1 | 1: controller must acknowledge with a low pulse |
| nfault_o | output | 1 | Handshake/fault pin, low while ready-but-not-released |
| state_o | output | 3 | Current sequencer state |

## Verification
The wake sequence runs in both release modes, entered from a sleep-pin rise and from a supply-reset release, so that self-release can be told apart from acknowledged release. Low pulses on the sleep pin are applied at TPULSE_MIN-1, TPULSE_MIN, TSLEEP_MIN-1 and above TSLEEP_MIN cycles. These widths separate an ignored glitch, the narrowest and widest accepted acknowledge, and a return to SLEEP. An acknowledge-width pulse sent during INIT shows whether pulses are gated on the completion of initialization. Every state change is compared in order against a queue of expected states and pin levels. The lengths of WAKE and INIT are measured against TWAKE and TINIT.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;
   typedef enum logic [2:0] {
      ST_SLEEP    = 3'd0,
      ST_WAKE     = 3'd1,
      ST_INIT     = 3'd2,
      ST_WAIT_ACK = 3'd3,
      ST_STANDBY  = 3'd4
   } wake_state_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad
         $error("wake_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) stg <= '0;
      else     stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/wake_low_meter.sv
module wake_low_meter #(
   parameter int TPULSE_MIN = 4,
   parameter int TSLEEP_MIN = 40
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic pulse_ok,
   output logic sleep_req
);
   localparam int CW = $clog2(TSLEEP_MIN + 1);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)                             low_cnt <= CW'(TSLEEP_MIN);
      else if (lvl)                        low_cnt <= '0;
      else if (low_cnt < CW'(TSLEEP_MIN))  low_cnt <= low_cnt + 1'b1;
   end

   assign sleep_req = !lvl && (low_cnt >= CW'(TSLEEP_MIN - 1));
   assign pulse_ok  = lvl && (low_cnt >= CW'(TPULSE_MIN)) && (low_cnt < CW'(TSLEEP_MIN));

   // R6
   pulse_after_low_chk: assert property (@(posedge clk) disable iff (rst)
      pulse_ok |-> $past(!lvl));
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
   import wake_seq_pkg::*;
#(
   parameter int TWAKE = 3,
   parameter int TINIT = 64
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        lvl,
   input  logic        ack_mode,
   input  logic        pulse_ok,
   input  logic        sleep_req,
   output wake_state_e state
);
   localparam int CMAX = (TWAKE > TINIT) ? TWAKE : TINIT;
   localparam int CW   = $clog2(CMAX + 1);

   wake_state_e   nxt;
   logic [CW-1:0] cnt;
   logic          armed;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_SLEEP:    if (lvl) nxt = ST_WAKE;
         ST_WAKE:     if (cnt == CW'(TWAKE - 1)) nxt = ST_INIT;
         ST_INIT:     if (cnt == CW'(TINIT - 1)) nxt = ack_mode ? ST_WAIT_ACK : ST_STANDBY;
         ST_WAIT_ACK: if (pulse_ok && armed) nxt = ST_STANDBY;
         ST_STANDBY:  nxt = ST_STANDBY;
         default:     nxt = ST_SLEEP;
      endcase
      if (sleep_req && state != ST_SLEEP) nxt = ST_SLEEP;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state <= ST_SLEEP;
         cnt   <= '0;
         armed <= 1'b0;
      end else begin
         state <= nxt;
         cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
         armed <= (state == ST_WAIT_ACK && nxt == ST_WAIT_ACK) ? (armed | lvl) : 1'b0;
      end
   end

   // R2
   sleep_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_SLEEP) |=> (state == ST_SLEEP || state == ST_WAKE));
   // R3
   init_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_INIT && $past(state) != ST_INIT) |-> ($past(state) == ST_WAKE));
   // R6
   ack_release_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_STANDBY && $past(state) == ST_WAIT_ACK) |-> $past(pulse_ok));
   // R9
   long_low_chk: assert property (@(posedge clk) disable iff (rst)
      sleep_req |=> (state == ST_SLEEP));
endmodule

// File: rtl/wake_handshake_seq.sv
module wake_handshake_seq
   import wake_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TWAKE       = 3,
   parameter int TINIT       = 64,
   parameter int TPULSE_MIN  = 4,
   parameter int TSLEEP_MIN  = 40
) (
   input  logic       clk,
   input  logic       por_i,
   input  logic       nsleep_i,
   input  logic       ack_mode_i,
   output logic       nfault_o,
   output logic [2:0] state_o
);
   generate
      if (TWAKE < 1 || TINIT < 1) begin : g_bad_time
         $error("wake_handshake_seq: TWAKE and TINIT must be positive");
      end
      if (TPULSE_MIN < 1 || TSLEEP_MIN <= TPULSE_MIN) begin : g_bad_pulse
         $error("wake_handshake_seq: need 1 <= TPULSE_MIN < TSLEEP_MIN");
      end
   endgenerate

   logic        lvl, pulse_ok, sleep_req;
   wake_state_e state;

   wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(por_i), .d(nsleep_i), .q(lvl)
   );

   wake_low_meter #(.TPULSE_MIN(TPULSE_MIN), .TSLEEP_MIN(TSLEEP_MIN)) u_meter (
      .clk(clk), .rst(por_i), .lvl(lvl), .pulse_ok(pulse_ok), .sleep_req(sleep_req)
   );

   wake_fsm #(.TWAKE(TWAKE), .TINIT(TINIT)) u_fsm (
      .clk(clk), .rst(por_i), .lvl(lvl), .ack_mode(ack_mode_i),
      .pulse_ok(pulse_ok), .sleep_req(sleep_req), .state(state)
   );

   assign nfault_o = !(state == ST_INIT || state == ST_WAIT_ACK);
   assign state_o  = state;

   // R1
   por_hold_chk: assert property (@(posedge clk)
      por_i |-> (nfault_o && state_o == 3'd0));
endmodule

// File: tb/wake_handshake_seq_test.sv
module wake_handshake_seq_test;
   localparam int TWAKE = 3, TINIT = 64, TPULSE_MIN = 4, TSLEEP_MIN = 40;

   logic       clk = 1'b0, por = 1'b1, nsl = 1'b0, ackm = 1'b0;
   logic       nfault;
   logic [2:0] st;

   always #2 clk = ~clk;

   wake_handshake_seq #(.TWAKE(TWAKE), .TINIT(TINIT), .TPULSE_MIN(TPULSE_MIN),
                        .TSLEEP_MIN(TSLEEP_MIN)) uut (
      .clk(clk), .por_i(por), .nsleep_i(nsl), .ack_mode_i(ackm),
      .nfault_o(nfault), .state_o(st)
   );

   typedef struct { logic [2:0] s; logic nf; string req; } exp_t;
   exp_t       q[$];
   exp_t       cur;
   int         checks = 0, fails = 0;
   int         dur[8];
   int         run_len = 0;
   logic [2:0] prev_st = 3'd0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic expect_st(logic [2:0] s, logic nf, string req);
      q.push_back('{s, nf, req});
   endtask

   task automatic wait_state(logic [2:0] s, int lim, string req);
      int n = 0;
      while (st !== s && n < lim) begin
         @(negedge clk);
         n++;
      end
      chk(st === s, req, "reached state", int'(st), int'(s));
   endtask

   task automatic low_pulse(int n);
      @(negedge clk) nsl = 1'b0;
      repeat (n) @(negedge clk);
      nsl = 1'b1;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // monitor: every state change is popped against the scoreboard
   always @(negedge clk) begin
      if (st !== prev_st) begin
         dur[prev_st] = run_len;
         run_len = 1;
         if (q.size() == 0) begin
            chk(1'b0, "R11", "unexpected state change", int'(st), int'(prev_st));
         end else begin
            cur = q.pop_front();
            chk(st === cur.s, cur.req, "state", int'(st), int'(cur.s));
            chk(nfault === cur.nf, cur.req, "nfault", int'(nfault), int'(cur.nf));
         end
         prev_st = st;
      end else begin
         run_len++;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", int'(st), 4);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(st == 3'd0, "R1", "reset state", int'(st), 0);
      chk(nfault == 1'b1, "R1", "reset nfault", int'(nfault), 1);
      por = 1'b0;
      repeat (5) @(negedge clk);
      chk(st == 3'd0, "R2", "sleep with nsleep low", int'(st), 0);

      // R2 R3 R4: wake without acknowledge
      expect_st(3'd1, 1'b1, "R2");
      expect_st(3'd2, 1'b0, "R3");
      expect_st(3'd4, 1'b1, "R4");
      nsl = 1'b1;
      repeat (2) @(negedge clk);
      chk(st == 3'd0, "R2", "still sleep during sync", int'(st), 0);
      @(negedge clk);
      chk(st == 3'd1, "R2", "wake latency", int'(st), 1);
      wait_state(3'd4, 200, "R4");
      @(negedge clk);
      chk(dur[1] == TWAKE, "R2", "wake length", dur[1], TWAKE);
      chk(dur[2] == TINIT, "R3", "init length", dur[2], TINIT);

      // R9 from STANDBY
      expect_st(3'd0, 1'b1, "R9");
      nsl = 1'b0;
      repeat (TSLEEP_MIN + 5) @(negedge clk);
      wait_state(3'd0, 10, "R9");

      // R5 R8: acknowledge mode, pulse during INIT ignored
      ackm = 1'b1;
      expect_st(3'd1, 1'b1, "R5");
      expect_st(3'd2, 1'b0, "R8");
      expect_st(3'd3, 1'b0, "R5");
      nsl = 1'b1;
      wait_state(3'd2, 20, "R5");
      repeat (10) @(negedge clk);
      low_pulse(8);
      wait_state(3'd3, 100, "R8");
      @(negedge clk);
      chk(dur[2] == TINIT, "R8", "init length with pulse", dur[2], TINIT);
      repeat (10) @(negedge clk);
      chk(st == 3'd3, "R5", "held in wait_ack", int'(st), 3);
      chk(nfault == 1'b0, "R5", "nfault held low", int'(nfault), 0);

      // R7: too-short pulse
      low_pulse(TPULSE_MIN - 1);
      repeat (10) @(negedge clk);
      chk(st == 3'd3, "R7", "short pulse state", int'(st), 3);
      chk(nfault == 1'b0, "R7", "short pulse nfault", int'(nfault), 0);

      // R6: shortest accepted pulse
      expect_st(3'd4, 1'b1, "R6");
      low_pulse(TPULSE_MIN);
      wait_state(3'd4, 20, "R6");

      // R6: longest accepted pulse
      expect_st(3'd0, 1'b1, "R9");
      nsl = 1'b0;
      repeat (TSLEEP_MIN + 5) @(negedge clk);
      wait_state(3'd0, 10, "R9");
      expect_st(3'd1, 1'b1, "R2");
      expect_st(3'd2, 1'b0, "R3");
      expect_st(3'd3, 1'b0, "R5");
      nsl = 1'b1;
      wait_state(3'd3, 200, "R5");
      repeat (5) @(negedge clk);
      expect_st(3'd4, 1'b1, "R6");
      low_pulse(TSLEEP_MIN - 1);
      wait_state(3'd4, 20, "R6");

      // R9 from WAIT_ACK
      expect_st(3'd0, 1'b1, "R9");
      nsl = 1'b0;
      repeat (TSLEEP_MIN + 5) @(negedge clk);
      wait_state(3'd0, 10, "R9");
      expect_st(3'd1, 1'b1, "R2");
      expect_st(3'd2, 1'b0, "R3");
      expect_st(3'd3, 1'b0, "R5");
      nsl = 1'b1;
      wait_state(3'd3, 200, "R5");
      repeat (5) @(negedge clk);
      expect_st(3'd0, 1'b1, "R9");
      nsl = 1'b0;
      repeat (TSLEEP_MIN + 5) @(negedge clk);
      wait_state(3'd0, 10, "R9");
      chk(nfault == 1'b1, "R9", "nfault released in sleep", int'(nfault), 1);

      // R10: supply reset release with nsleep high
      ackm = 1'b0;
      por = 1'b1;
      nsl = 1'b1;
      repeat (5) @(negedge clk);
      chk(st == 3'd0, "R1", "held by por with nsleep high", int'(st), 0);
      expect_st(3'd1, 1'b1, "R10");
      expect_st(3'd2, 1'b0, "R10");
      expect_st(3'd4, 1'b1, "R10");
      por = 1'b0;
      wait_state(3'd4, 200, "R10");
      @(negedge clk);
      chk(dur[2] == TINIT, "R10", "init length after por", dur[2], TINIT);

      // R1: por asserted from STANDBY
      expect_st(3'd0, 1'b1, "R1");
      por = 1'b1;
      @(negedge clk);
      chk(st == 3'd0, "R1", "por forces sleep", int'(st), 0);
      chk(nfault == 1'b1, "R1", "por nfault", int'(nfault), 1);
      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R11", "expected changes left", q.size(), 0);
      summary();
   end
endmodule